// File: doc/BRIEF.md
# Oscillator Calibration Counter

This block compares the rate of one clock source against another. Software picks a "down" source and an "up" source from a small set of oscillator inputs and programs a window length. After a start command, the block counts rising edges of the up source until the down source has produced the programmed number of edges. The count that has built up by then is latched as the result. Software can then scale a tuning value from that ratio. The tuning loop and the oscillators themselves sit outside this block.

All logic runs on one system clock. Each oscillator input passes through a synchronizer and an edge detector, so a source must run well below half the system clock rate. A one-shot measurement stops when it completes. In continuous mode the block re-arms itself on completion, so software only has to read the latest result. Every completion raises a ready flag. That flag drives an interrupt line through an enable bit, and software can set or clear it through dedicated write addresses.

The block has no streaming data path. The register port is a plain single-cycle write strobe with a combinational read mux, and it has no back-pressure.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, busy (STATUS address 3, bit 0), the result (address 4), the ready flag (address 5, bit 0) and irq_o all read 0.
- R2: The configuration word at address 0 holds the up select in bits [2:0], the down select in bits [6:4] and continuous mode in bit 8. A select code below NSRC picks src_clk_i[code]. Any other code yields no edges at all.
- R3: A measurement counts the up-source rising edges seen from the start command until the (TOP+1)-th down-source rising edge, where TOP is the value at address 1. That count becomes the result.
- R4: Writing bit 0 = 1 to address 2 starts a measurement and sets busy. In one-shot mode busy drops on completion, and the result then holds against further edges.
- R5: A start written while busy is ignored, and the running measurement continues unchanged.
- R6: The up count saturates at 2^CNT_W-1 instead of wrapping.
- R7: In continuous mode a completion updates the result, reloads TOP and starts a new window at once, so busy stays 1.
- R8: Clearing continuous mode during a window lets that window complete, after which busy drops.
- R9: Each completion sets the ready flag. Writing bit 0 = 1 to address 6 sets it, and writing bit 0 = 1 to address 7 clears it. A completion wins over a clear in the same cycle.
- R10: irq_o equals the ready flag ANDed with the enable bit (address 8, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | NSRC | Oscillator inputs, sampled in the clk domain |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from bus_addr_i |
| irq_o | output | 1 | Ready interrupt |

## Verification
- **Down counter wrong:** the result becomes a wrong multiple of the up-edge rate. It becomes visible a few cycles after the final down edge, once the synchronizer latency has passed.
- **Up counter wraps:** a wrapping up counter shows up as a small result after a long window.
- **Lost re-arm:** a dropped re-arm shows as busy reading 0 right after a continuous completion.
- **Flag or enable logic wrong:** this reaches irq_o in the cycle after the write or completion that should have changed it.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int SEL_W     = 3;
  localparam int UPSEL_LSB = 0;
  localparam int DNSEL_LSB = 4;
  localparam int CONT_BIT  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG      = 4'd0,
    REG_TOP      = 4'd1,
    REG_CMD      = 4'd2,
    REG_STATUS   = 4'd3,
    REG_RESULT   = 4'd4,
    REG_FLAG     = 4'd5,
    REG_FLAG_SET = 4'd6,
    REG_FLAG_CLR = 4'd7,
    REG_IEN      = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/osc_cal_edge.sv
module osc_cal_edge #(
  parameter int NSRC        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] tick_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], src_i[g]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end
    assign tick_o[g] = sync_q[SYNC_STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/osc_cal_core.sv
module osc_cal_core #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             up_tick_i,
  input  logic             dn_tick_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             busy_q;
  logic [CNT_W-1:0] dn_cnt_q;
  logic [CNT_W-1:0] up_cnt_q;
  logic [CNT_W-1:0] up_next;
  logic             launch;

  assign launch  = start_i & ~busy_q;
  assign done_o  = busy_q & dn_tick_i & (dn_cnt_q == '0);
  assign up_next = (up_tick_i && up_cnt_q != CNT_MAX) ? up_cnt_q + 1'b1 : up_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dn_cnt_q <= '0;
      up_cnt_q <= '0;
      result_o <= '0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      dn_cnt_q <= top_i;
      up_cnt_q <= '0;
    end else if (done_o) begin
      result_o <= up_next;
      up_cnt_q <= '0;
      dn_cnt_q <= top_i;
      busy_q   <= cont_i;
    end else if (busy_q) begin
      up_cnt_q <= up_next;
      if (dn_tick_i) dn_cnt_q <= dn_cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/osc_cal_regs.sv
module osc_cal_regs
  import osc_cal_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  result_i,
  output logic [SEL_W-1:0]  up_sel_o,
  output logic [SEL_W-1:0]  dn_sel_o,
  output logic              cont_o,
  output logic [CNT_W-1:0]  top_o,
  output logic              start_o,
  output logic              irq_o
);
  logic flag_q;
  logic ien_q;
  logic wr_cfg, wr_top, wr_set, wr_clr, wr_ien;
  wire  unused_wdata = ^wdata_i;

  assign wr_cfg  = we_i && (addr_i == REG_CFG);
  assign wr_top  = we_i && (addr_i == REG_TOP);
  assign wr_set  = we_i && (addr_i == REG_FLAG_SET) && wdata_i[0];
  assign wr_clr  = we_i && (addr_i == REG_FLAG_CLR) && wdata_i[0];
  assign wr_ien  = we_i && (addr_i == REG_IEN);
  assign start_o = we_i && (addr_i == REG_CMD) && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_sel_o <= '0;
      dn_sel_o <= '0;
      cont_o   <= 1'b0;
      top_o    <= '0;
      flag_q   <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (wr_cfg) begin
        up_sel_o <= wdata_i[UPSEL_LSB +: SEL_W];
        dn_sel_o <= wdata_i[DNSEL_LSB +: SEL_W];
        cont_o   <= wdata_i[CONT_BIT];
      end
      if (wr_top) top_o <= wdata_i[CNT_W-1:0];
      if (wr_ien) ien_q <= wdata_i[0];
      flag_q <= done_i | wr_set | (flag_q & ~wr_clr);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CFG: begin
        rdata_o[UPSEL_LSB +: SEL_W] = up_sel_o;
        rdata_o[DNSEL_LSB +: SEL_W] = dn_sel_o;
        rdata_o[CONT_BIT]           = cont_o;
      end
      REG_TOP:    rdata_o[CNT_W-1:0] = top_o;
      REG_STATUS: rdata_o[0]         = busy_i;
      REG_RESULT: rdata_o[CNT_W-1:0] = result_i;
      REG_FLAG:   rdata_o[0]         = flag_q;
      REG_IEN:    rdata_o[0]         = ien_q;
      default:    rdata_o            = '0;
    endcase
  end

  assign irq_o = flag_q & ien_q;
endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter
  import osc_cal_pkg::*;
#(
  parameter int NSRC        = 5,
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_clk_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [NSRC-1:0]  ticks;
  logic [SEL_W-1:0] up_sel, dn_sel;
  logic             up_tick, dn_tick;
  logic             cont_en, start_req;
  logic             core_busy, core_done;
  logic [CNT_W-1:0] top_val, result;

  osc_cal_edge #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_clk_i), .tick_o(ticks)
  );

  always_comb begin
    up_tick = 1'b0;
    dn_tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (32'(up_sel) == i) up_tick = ticks[i];
      if (32'(dn_sel) == i) dn_tick = ticks[i];
    end
  end

  osc_cal_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start_i(start_req), .cont_i(cont_en),
    .top_i(top_val), .up_tick_i(up_tick), .dn_tick_i(dn_tick),
    .busy_o(core_busy), .done_o(core_done), .result_o(result)
  );

  osc_cal_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .busy_i(core_busy),
    .done_i(core_done), .result_i(result), .up_sel_o(up_sel),
    .dn_sel_o(dn_sel), .cont_o(cont_en), .top_o(top_val),
    .start_o(start_req), .irq_o(irq_o)
  );
endmodule

// File: rtl/osc_cal_counter_chk.sv
module osc_cal_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             start_req,
  input logic             cont,
  input logic             flag,
  input logic             ien,
  input logic             irq,
  input logic [CNT_W-1:0] up_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r4_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_req && !done) |=> busy);

  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !done) |=> (busy && !$rose(busy)));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && up_cnt == CMAX) |=> (up_cnt == CMAX));

  a_r7_cont_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cont) |=> busy);

  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && flag));
endmodule

bind osc_cal_counter osc_cal_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(core_busy), .done(core_done),
  .start_req(start_req), .cont(cont_en), .flag(u_regs.flag_q),
  .ien(u_regs.ien_q), .irq(irq_o), .up_cnt(u_core.up_cnt_q)
);

// File: tb/tb_osc_cal_counter.sv
`timescale 1ns/1ps
module tb_osc_cal_counter;
  localparam int CW = 8;
  localparam int NS = 5;
  // columns: top, up edges per down edge, up select, down select, expected result
  localparam int NV = 5;
  localparam int VEC [NV][5] = '{
    '{0, 3, 0, 1, 3},
    '{2, 2, 2, 4, 6},
    '{4, 1, 3, 0, 5},
    '{1, 0, 1, 2, 0},
    '{3, 5, 4, 3, 20}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  osc_cal_counter #(.NSRC(NS), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .src_clk_i(src), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = 32'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 4'(a); #1; v = int'(rdata);
  endtask

  task automatic pulse(input int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  function automatic int cfgw(input int up, input int dn, input int cont);
    return up | (dn << 4) | (cont << 8);
  endfunction

  task automatic window(input int top, input int ups, input int up, input int dn);
    for (int k = 0; k <= top; k++) begin
      for (int j = 0; j < ups; j++) pulse(up);
      pulse(dn);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3, v); check("R1 busy", v, 0);
    rd(4, v); check("R1 result", v, 0);
    rd(5, v); check("R1 flag", v, 0);
    check("R1 irq", int'(irq), 0);

    // R3/R4/R9 vector table
    for (int n = 0; n < NV; n++) begin
      wr(0, cfgw(VEC[n][2], VEC[n][3], 0));
      wr(1, VEC[n][0]);
      wr(7, 1);
      wr(2, 1);
      rd(3, v); check("R4 busy set", v, 1);
      window(VEC[n][0], VEC[n][1], VEC[n][2], VEC[n][3]);
      settle();
      rd(4, v); check("R3 result", v, VEC[n][4]);
      rd(3, v); check("R4 busy clear", v, 0);
      rd(5, v); check("R9 flag on done", v, 1);
    end

    // R4 result holds after one-shot completion
    pulse(4); pulse(4); settle();
    rd(4, v); check("R4 result held", v, 20);

    // R5 start while busy ignored
    wr(0, cfgw(0, 1, 0)); wr(1, 2); wr(2, 1);
    window(0, 2, 0, 1);
    wr(2, 1);
    window(1, 2, 0, 1);
    settle();
    rd(4, v); check("R5 result", v, 6);
    rd(3, v); check("R5 busy", v, 0);

    // R6 saturation
    wr(1, 0); wr(2, 1);
    for (int j = 0; j < 300; j++) pulse(0);
    pulse(1); settle();
    rd(4, v); check("R6 saturate", v, 255);

    // R2 invalid up select
    wr(0, cfgw(6, 1, 0)); wr(2, 1);
    pulse(0); pulse(0); pulse(0); pulse(1); settle();
    rd(4, v); check("R2 invalid up sel", v, 0);
    rd(3, v); check("R2 down still works", v, 0);

    // R2 invalid down select stalls, then a valid one completes
    wr(0, cfgw(0, 5, 0)); wr(2, 1);
    pulse(0); pulse(0);
    for (int i = 0; i < NS; i++) pulse(i);
    settle();
    rd(3, v); check("R2 invalid down sel", v, 1);
    wr(0, cfgw(0, 1, 0));
    pulse(1); settle();
    rd(4, v); check("R2 result after reselect", v, 3);

    // R7 continuous mode, R8 stop
    wr(0, cfgw(2, 3, 1)); wr(1, 1); wr(7, 1); wr(2, 1);
    window(1, 2, 2, 3); settle();
    rd(4, v); check("R7 first window", v, 4);
    rd(3, v); check("R7 busy stays", v, 1);
    rd(5, v); check("R7 flag", v, 1);
    wr(7, 1);
    window(1, 3, 2, 3); settle();
    rd(4, v); check("R7 second window", v, 6);
    rd(3, v); check("R7 busy still", v, 1);
    wr(0, cfgw(2, 3, 0));
    window(1, 1, 2, 3); settle();
    rd(4, v); check("R8 last window", v, 2);
    rd(3, v); check("R8 busy drops", v, 0);

    // R9/R10 flag and interrupt
    wr(8, 0);
    rd(5, v); check("R9 flag pending", v, 1);
    check("R10 irq masked", int'(irq), 0);
    wr(8, 1);
    check("R10 irq enabled", int'(irq), 1);
    wr(7, 1);
    rd(5, v); check("R9 flag cleared", v, 0);
    check("R10 irq after clear", int'(irq), 0);
    wr(6, 1);
    rd(5, v); check("R9 flag set by write", v, 1);
    check("R10 irq after set", int'(irq), 1);

    summary();
    $finish;
  end
endmodule